// File: doc/BRIEF.md
# Monitor Sync Input Processor

This block sits between a display monitor's two logic-level sync inputs and its line timing loop. One input carries horizontal sync alone or a composite of horizontal and vertical sync; the other carries a separate vertical sync. Both inputs pass through a two-flop synchroniser and a short-glitch filter. An integrator then learns which level each input rests at, and the pulse is turned so that its active part is always high. In the rest of this brief, a pulse is "active" while it is in that high, normalised state.

A state machine watches the normalised horizontal/composite pulse. It measures the distance between accepted leading edges in system clock cycles and stores it as the line period. It rejects pulses that are too short. It drops leading edges that arrive too early, which removes half-line equalizing pulses. For each accepted line it gives a one-cycle strobe at a fixed delay after the leading edge. A pulse that stays active for more than a quarter of the line period is treated as an embedded vertical pulse. While that pulse lasts, the block asserts an inhibit that freezes the line phase comparator.

A sync-type select chooses which source drives the vertical output: the separate vertical input or the pulse extracted from the composite. Three sticky flags record activity for software: line activity, separate-vertical activity, and extracted-vertical activity. A refresh command clears all three.

The states of the line state machine are:
- LS_WAIT: waiting for a leading edge.
- LS_LINE: an accepted pulse is active and its width is being counted.
- LS_VERT: an embedded vertical pulse is active.
- LS_SKIP: a rejected pulse is active and is ignored until it ends.

The transitions are:
- LS_WAIT to LS_LINE on an edge that is accepted.
- LS_WAIT to LS_SKIP on an edge that comes too early.
- LS_LINE to LS_VERT when the width reaches a quarter of the line period.
- LS_VERT to LS_SKIP when the width reaches VMAX.
- LS_LINE, LS_VERT and LS_SKIP each return to LS_WAIT when the pulse ends.

Top module: `sync_front`

## Requirements
- R1: After reset, every output is 0.
- R2: Each input has its own integrator, a counter clamped to the range from -POL_CYC to +POL_CYC. The counter steps up in each cycle the filtered input is high and down in each cycle it is low. The negative-polarity flag (h_neg or v_neg) becomes 1 only when the counter reaches +POL_CYC, and becomes 0 only when it reaches -POL_CYC. An input held high from reset therefore sets its flag after no fewer than POL_CYC cycles and within about 2*POL_CYC cycles.
- R3: h_sync is a one-cycle strobe. It comes a fixed number of cycles after each accepted leading edge of the normalised pulse. The spacing between strobes therefore equals the spacing between the input's active edges, whichever polarity the input has.
- R4: An input change lasting fewer than GLITCH cycles is ignored. A normalised pulse shorter than MIN_W cycles produces no strobe and does not set h_det.
- R5: Once a line period is known, a leading edge that comes less than three quarters of that period after the previous accepted edge is dropped, and no strobe results.
- R6: A line pulse whose active width reaches a quarter of the known period raises inhibit. Inhibit stays high until the pulse ends, or until the width reaches VMAX, whichever comes first. No strobe is given while inhibit is high.
- R7: When sep_sel is 1, v_sync goes high once the separate vertical pulse has been active for VMIN cycles, and falls one cycle after that pulse ends. A shorter pulse gives no v_sync and does not set v_det.
- R8: When sep_sel is 0, v_sync equals the extracted vertical inhibit.
- R9: Three sticky flags are set by events:
  - h_det is set by a strobe.
  - v_det is set by the rise of the separate vertical output.
  - vx_det is set by the rise of inhibit.

  Each flag holds until refresh is 1, and a refresh clears all three flags.
- R10: If a set event and refresh fall in the same cycle, the set wins and the flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_in | input | 1 | Horizontal or composite sync input |
| v_in | input | 1 | Separate vertical sync input |
| sep_sel | input | 1 | Vertical source: 1 selects the separate input, 0 selects composite extraction |
| refresh | input | 1 | Clears the detection flags |
| h_sync | output | 1 | One-cycle strobe for each accepted line |
| v_sync | output | 1 | Selected vertical sync, active high |
| inhibit | output | 1 | Freezes the line phase comparator during an extracted vertical pulse |
| h_neg | output | 1 | hv_in was learned as active-low |
| v_neg | output | 1 | v_in was learned as active-low |
| h_det | output | 1 | Sticky flag: line activity |
| v_det | output | 1 | Sticky flag: separate vertical activity |
| vx_det | output | 1 | Sticky flag: vertical extracted from composite |

## Verification
A line strobe and a refresh command can land on the same clock edge, and the two pull h_det in opposite directions. The bench first waits for a strobe while the line period is steady. It then counts exactly one line period of cycles and raises refresh for a single cycle. It confirms that a strobe is present in that same cycle, and it expects h_det to read 1 afterwards, because a set takes priority over a clear.

// File: rtl/sync_pkg.sv
package sync_pkg;
    typedef enum logic [1:0] {
        LS_WAIT = 2'd0,
        LS_LINE = 2'd1,
        LS_VERT = 2'd2,
        LS_SKIP = 2'd3
    } line_state_t;
endpackage

// File: rtl/sync_cond.sv
module sync_cond #(
    parameter int GLITCH  = 4,
    parameter int POL_CYC = 187500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic pulse,
    output logic neg
);
    localparam int GW = $clog2(GLITCH + 1);
    localparam int AW = $clog2(POL_CYC + 1) + 1;
    localparam logic signed [AW-1:0] A_HI = AW'(POL_CYC);
    localparam logic signed [AW-1:0] A_LO = AW'(-POL_CYC);

    logic [1:0]            sy;
    logic                  filt;
    logic [GW-1:0]         gcnt;
    logic signed [AW-1:0]  acc;

    // two-flop synchroniser, then a persistence filter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy   <= '0;
            filt <= 1'b0;
            gcnt <= '0;
        end else begin
            sy <= {sy[0], raw};
            if (sy[1] == filt) begin
                gcnt <= '0;
            end else if (gcnt == GW'(GLITCH - 1)) begin
                filt <= sy[1];
                gcnt <= '0;
            end else begin
                gcnt <= gcnt + 1'b1;
            end
        end
    end

    // level integrator with hysteresis at both rails
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            neg <= 1'b0;
        end else begin
            if (filt && acc != A_HI)
                acc <= acc + 1'b1;
            else if (!filt && acc != A_LO)
                acc <= acc - 1'b1;
            if (acc == A_HI)
                neg <= 1'b1;
            else if (acc == A_LO)
                neg <= 1'b0;
        end
    end

    assign pulse = filt ^ neg;
endmodule

// File: rtl/vpulse_gate.sv
module vpulse_gate #(
    parameter int VMIN = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic gated
);
    localparam int VW = $clog2(VMIN + 1);
    logic [VW-1:0] vc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vc    <= '0;
            gated <= 1'b0;
        end else if (!pulse) begin
            vc    <= '0;
            gated <= 1'b0;
        end else if (vc == VW'(VMIN - 1)) begin
            gated <= 1'b1;
        end else begin
            vc <= vc + 1'b1;
        end
    end
endmodule

// File: rtl/line_sep.sv
module line_sep
    import sync_pkg::*;
#(
    parameter int MIN_W   = 175,
    parameter int VMAX    = 187500,
    parameter int PER_MAX = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic strobe,
    output logic vert
);
    localparam int PW = $clog2(PER_MAX + 1);
    localparam int WW = $clog2(VMAX + 1);
    localparam int CW = ((PW > WW) ? PW : WW) + 1;

    line_state_t   st, st_nx;
    logic [PW-1:0] per_cnt, cand, lastper;
    logic [WW-1:0] wid;
    logic          seen, known, after_v;
    logic [CW-1:0] quarter, okthr, wid_x, per_x, slack;
    logic          per_sat, commit, accept;

    always_comb begin
        quarter = CW'(lastper >> 2);
        okthr   = CW'(lastper) - quarter;
        slack   = CW'(lastper) + quarter;
        wid_x   = CW'(wid);
        per_x   = CW'(per_cnt);
        per_sat = (per_cnt == PW'(PER_MAX));
        commit  = (st == LS_LINE) && pulse && (wid == WW'(MIN_W - 1));
        accept  = (st == LS_WAIT) && pulse && (!known || per_x >= okthr);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LS_WAIT: if (pulse) st_nx = accept ? LS_LINE : LS_SKIP;
            LS_LINE: begin
                if (!pulse)
                    st_nx = LS_WAIT;
                else if (known && wid >= WW'(MIN_W) && wid_x >= quarter)
                    st_nx = LS_VERT;
            end
            LS_VERT: begin
                if (!pulse)
                    st_nx = LS_WAIT;
                else if (wid >= WW'(VMAX))
                    st_nx = LS_SKIP;
            end
            LS_SKIP: if (!pulse) st_nx = LS_WAIT;
            default: st_nx = LS_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LS_WAIT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt <= '0;
            cand    <= '0;
            lastper <= '0;
            wid     <= '0;
            seen    <= 1'b0;
            known   <= 1'b0;
            after_v <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            if (!per_sat)
                per_cnt <= per_cnt + 1'b1;
            if (per_sat) begin
                seen  <= 1'b0;
                known <= 1'b0;
            end
            if (accept)
                cand <= per_cnt;
            if (commit) begin
                lastper <= cand;
                known   <= seen && !after_v && (!known || CW'(cand) <= slack);
                seen    <= 1'b1;
                after_v <= 1'b0;
                per_cnt <= PW'(MIN_W);
            end
            if (st == LS_WAIT && pulse)
                wid <= WW'(1);
            else if ((st == LS_LINE || st == LS_VERT) && pulse && wid != WW'(VMAX))
                wid <= wid + 1'b1;
            if (st == LS_LINE && st_nx == LS_VERT)
                after_v <= 1'b1;
            strobe <= commit;
        end
    end

    always_comb begin
        vert = (st == LS_VERT);
    end
endmodule

// File: rtl/sync_front.sv
module sync_front #(
    parameter int GLITCH  = 4,
    parameter int POL_CYC = 187500,
    parameter int MIN_W   = 175,
    parameter int VMIN    = 1250,
    parameter int VMAX    = 187500,
    parameter int PER_MAX = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hv_in,
    input  logic v_in,
    input  logic sep_sel,
    input  logic refresh,
    output logic h_sync,
    output logic v_sync,
    output logic inhibit,
    output logic h_neg,
    output logic v_neg,
    output logic h_det,
    output logic v_det,
    output logic vx_det
);
    logic [1:0] raw, pul, negs;
    logic       vx, vsep, vx_q, vs_q;

    assign raw = {v_in, hv_in};

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        sync_cond #(.GLITCH(GLITCH), .POL_CYC(POL_CYC)) u_cond (
            .clk(clk), .rst_n(rst_n), .raw(raw[ch]),
            .pulse(pul[ch]), .neg(negs[ch])
        );
    end

    line_sep #(.MIN_W(MIN_W), .VMAX(VMAX), .PER_MAX(PER_MAX)) u_line (
        .clk(clk), .rst_n(rst_n), .pulse(pul[0]),
        .strobe(h_sync), .vert(vx)
    );

    vpulse_gate #(.VMIN(VMIN)) u_vgate (
        .clk(clk), .rst_n(rst_n), .pulse(pul[1]), .gated(vsep)
    );

    assign inhibit = vx;
    assign v_sync  = sep_sel ? vsep : vx;
    assign h_neg   = negs[0];
    assign v_neg   = negs[1];

    // sticky flags: a set in the same cycle as refresh wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vx_q   <= 1'b0;
            vs_q   <= 1'b0;
            h_det  <= 1'b0;
            v_det  <= 1'b0;
            vx_det <= 1'b0;
        end else begin
            vx_q <= vx;
            vs_q <= vsep;
            if (refresh) begin
                h_det  <= 1'b0;
                v_det  <= 1'b0;
                vx_det <= 1'b0;
            end
            if (h_sync)        h_det  <= 1'b1;
            if (vsep && !vs_q) v_det  <= 1'b1;
            if (vx && !vx_q)   vx_det <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_front_chk.sv
module sync_front_chk (
    input logic clk,
    input logic rst_n,
    input logic sep_sel,
    input logic refresh,
    input logic h_sync,
    input logic v_sync,
    input logic inhibit,
    input logic h_det
);
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        h_sync |=> !h_sync);

    a_r6_no_strobe_in_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !h_sync);

    a_r8_composite_vsel: assert property (@(posedge clk) disable iff (!rst_n)
        !sep_sel |-> (v_sync == inhibit));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (h_det && !refresh) |=> h_det);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !h_sync) |=> !h_det);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        h_sync |=> h_det);
endmodule

bind sync_front sync_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sep_sel(sep_sel), .refresh(refresh),
    .h_sync(h_sync), .v_sync(v_sync), .inhibit(inhibit), .h_det(h_det)
);

// File: tb/test_sync_front.sv
module test_sync_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv_in = 1'b0, v_in = 1'b0, sep_sel = 1'b0, refresh = 1'b0;
    logic h_sync, v_sync, inhibit, h_neg, v_neg, h_det, v_det, vx_det;

    int tests = 0, fails = 0;
    int cyc = 0, nstr = 0, last = 0, gap = 0;
    int irun = 0, imax = 0, vrun = 0, vmax = 0, mism = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_front #(.GLITCH(2), .POL_CYC(256), .MIN_W(8), .VMIN(20),
                 .VMAX(400), .PER_MAX(1023)) i_sync_front (
        .clk(clk), .rst_n(rst_n), .hv_in(hv_in), .v_in(v_in),
        .sep_sel(sep_sel), .refresh(refresh), .h_sync(h_sync),
        .v_sync(v_sync), .inhibit(inhibit), .h_neg(h_neg), .v_neg(v_neg),
        .h_det(h_det), .v_det(v_det), .vx_det(vx_det)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (h_sync) begin
            nstr = nstr + 1;
            gap  = cyc - last;
            last = cyc;
        end
        if (inhibit) begin
            irun = irun + 1;
            if (irun > imax) imax = irun;
        end else irun = 0;
        if (v_sync) begin
            vrun = vrun + 1;
            if (vrun > vmax) vmax = vrun;
        end else vrun = 0;
        if (!sep_sel && v_sync != inhibit) mism = mism + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic line(input int per, input int w, input bit inv);
        hv_in = !inv;
        repeat (w) @(negedge clk);
        hv_in = inv;
        repeat (per - w) @(negedge clk);
    endtask

    task automatic do_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk({h_sync, v_sync, inhibit, h_neg, v_neg, h_det, v_det, vx_det} == 8'h00,
            "R1 reset outputs", {h_sync, v_sync, inhibit, h_neg, v_neg, h_det, v_det, vx_det}, 0);
    endtask

    task automatic t_lines();
        repeat (6) line(200, 20, 0);
        chk(h_neg == 1'b0, "R2 positive input stays positive", h_neg, 0);
        chk(nstr >= 5, "R3 strobe count", nstr, 5);
        chk(gap == 200, "R3 strobe spacing", gap, 200);
        chk(h_det == 1'b1, "R9 line flag set", h_det, 1);
    endtask

    task automatic t_equalize();
        nstr = 0;
        repeat (4) line(100, 10, 0);
        repeat (3) line(200, 20, 0);
        chk(nstr == 5, "R5 half-line pulses dropped", nstr, 5);
        chk(gap == 200, "R5 spacing after equalizing", gap, 200);
    endtask

    task automatic t_short();
        hv_in = 1'b0;
        repeat (300) @(negedge clk);
        do_refresh();
        chk(h_det == 1'b0, "R9 refresh clears flag", h_det, 0);
        nstr = 0;
        repeat (3) line(200, 5, 0);
        hv_in = 1'b1;
        @(negedge clk);
        hv_in = 1'b0;
        repeat (50) @(negedge clk);
        chk(nstr == 0, "R4 short pulse and glitch give no strobe", nstr, 0);
        chk(h_det == 1'b0, "R4 short pulse leaves flag clear", h_det, 0);
    endtask

    task automatic t_vert();
        repeat (5) line(200, 20, 0);
        imax = 0; mism = 0;
        line(200, 120, 0);
        repeat (4) line(200, 20, 0);
        chk(imax >= 65 && imax <= 77, "R6 inhibit length", imax, 71);
        chk(vx_det == 1'b1, "R9 extracted vertical flag", vx_det, 1);
        chk(mism == 0, "R8 composite v_sync follows inhibit", mism, 0);
        chk(gap == 200, "R6 line spacing after vertical", gap, 200);
        repeat (2) line(200, 20, 0);
        imax = 0;
        line(700, 460, 0);
        repeat (4) line(200, 20, 0);
        chk(imax >= 340 && imax <= 360, "R6 inhibit capped at VMAX", imax, 351);
    endtask

    task automatic t_neg();
        line(200, 20, 1);
        chk(h_neg == 1'b0, "R2 no early polarity change", h_neg, 0);
        repeat (8) line(200, 20, 1);
        chk(h_neg == 1'b1, "R2 negative polarity learned", h_neg, 1);
        nstr = 0;
        repeat (3) line(200, 20, 1);
        chk(nstr == 3 && gap == 200, "R3 negative input strobe spacing", gap, 200);
        repeat (8) line(200, 20, 0);
        chk(h_neg == 1'b0, "R2 polarity returns positive", h_neg, 0);
    endtask

    task automatic t_sepv();
        sep_sel = 1'b1;
        hv_in = 1'b0;
        repeat (300) @(negedge clk);
        do_refresh();
        vmax = 0;
        repeat (2) begin
            v_in = 1'b1; repeat (15) @(negedge clk);
            v_in = 1'b0; repeat (300) @(negedge clk);
        end
        chk(vmax == 0, "R7 short vertical gives no v_sync", vmax, 0);
        chk(v_det == 1'b0, "R7 short vertical leaves flag clear", v_det, 0);
        v_in = 1'b1; repeat (60) @(negedge clk);
        v_in = 1'b0; repeat (300) @(negedge clk);
        chk(vmax >= 38 && vmax <= 44, "R7 separate vertical length", vmax, 41);
        chk(v_det == 1'b1, "R9 separate vertical flag", v_det, 1);
        sep_sel = 1'b0;
    endtask

    task automatic t_collide();
        bit aligned;
        aligned = 1'b0;
        fork
            repeat (12) line(200, 20, 0);
            begin
                repeat (5 * 200) @(negedge clk);
                do @(negedge clk); while (!h_sync);
                chk(h_det == 1'b1, "R10 flag set before collision", h_det, 1);
                repeat (200) @(negedge clk);
                aligned = h_sync;
                refresh = 1'b1;
                @(negedge clk);
                refresh = 1'b0;
                chk(aligned == 1'b1, "R10 refresh aligned with strobe", aligned, 1);
                chk(h_det == 1'b1, "R10 set wins over refresh", h_det, 1);
            end
        join
    endtask

    task automatic t_vneg();
        v_in = 1'b1;
        repeat (400) @(negedge clk);
        chk(v_neg == 1'b0, "R2 vertical polarity not yet changed", v_neg, 0);
        repeat (200) @(negedge clk);
        chk(v_neg == 1'b1, "R2 vertical negative polarity learned", v_neg, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lines();
        t_equalize();
        t_short();
        t_vert();
        t_neg();
        t_sepv();
        t_collide();
        t_vneg();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule